// File: doc/BRIEF.md
# Configurable Stream Pipeline Stage

This block is a pipeline register inserted between an upstream AXI4-Stream source and a downstream sink. It breaks long timing paths on a stream link. A single parameter chooses which direction is cut. The choices are the forward direction (valid plus payload), the backward direction (ready), both directions, or none at all, in which case the stage is plain wiring.

The payload is the data word together with its byte-keep and byte-strobe masks, the end-of-packet flag and the user field. These sideband fields are always handled as one word with the data, so they are delayed exactly when the data is delayed. Whenever the ready path is cut, a small skid store holds beats that were accepted while the registered ready was still high. This keeps every beat intact under any stall pattern and keeps a continuously ready sink fed at one beat per clock.

Top module: `axis_reg_slice`

## Requirements
- R1: With `MODE` left at its default, the stage behaves as the both-directions variant (value 3).
- R2: `MODE` = 0 (bypass): `m_tvalid`, the payload and `s_tready` equal `s_tvalid`, the input payload and `m_tready` in the same cycle.
- R3: `MODE` = 1 (forward): valid and payload appear at the output one clock after acceptance, and `s_tready` = `m_tready` OR NOT `m_tvalid` within the same cycle.
- R4: `MODE` = 2 (backward): `s_tready` is a register output. While `s_tready` is high, the output valid and payload equal the input in the same cycle. One beat offered into a stalled sink is captured, and ready then drops.
- R5: `MODE` = 3 (both): ready is a register output. A stalled sink lets exactly two beats enter, after which `s_tready` is low. `s_tready` only rises after a cycle with `m_tready` high.
- R6: The payload word is `{tuser, tlast, tstrb, tkeep, tdata}`, and every field of it leaves the stage with the beat it entered with.
- R7: Under any mix of source gaps and sink stalls, beats leave in the order they entered, with none lost or repeated. No more beats are held than the mode's capacity (0, 1, 1 or 2 for modes 0 to 3).
- R8: While `m_tvalid` is high and `m_tready` low, `m_tvalid` stays high and the payload stays unchanged in the next cycle.
- R9: With a source that always offers and a sink that is always ready, one beat per clock leaves the stage in every mode.
- R10: The reset is synchronous and active low. It empties the stage. In modes 1 and 3, `m_tvalid` is low in the first cycle after reset even if the source offers a beat. In modes 2 and 3, `s_tready` is high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_tdata | input | DATA_W | Upstream data |
| s_tkeep | input | DATA_W/8 | Upstream byte-keep mask |
| s_tstrb | input | DATA_W/8 | Upstream byte-strobe mask |
| s_tlast | input | 1 | Upstream end of packet |
| s_tuser | input | USER_W | Upstream user field |
| s_tvalid | input | 1 | Upstream beat valid |
| s_tready | output | 1 | Stage can accept a beat |
| m_tdata | output | DATA_W | Downstream data |
| m_tkeep | output | DATA_W/8 | Downstream byte-keep mask |
| m_tstrb | output | DATA_W/8 | Downstream byte-strobe mask |
| m_tlast | output | 1 | Downstream end of packet |
| m_tuser | output | USER_W | Downstream user field |
| m_tvalid | output | 1 | Downstream beat valid |
| m_tready | input | 1 | Sink accepts the beat |

## Verification
The hardest state to reach is the second storage entry in the both-directions variant: a beat taken in on the cycle after the sink stalled, while the first beat still sits at the output. The bench reaches it by having the source offer from the first cycle after reset while the sink holds ready low. The bench then sweeps sixteen pairings of source gap patterns (steady, alternating, hashed, sparse) with sink patterns (stalled, steady, alternating, hashed) across all four modes side by side. Every beat carries an index-derived payload, so any loss, repeat, reordering or mixed sideband field shows up at the output.

// File: rtl/axis_reg_slice.sv
module axis_reg_slice #(
  parameter int DATA_W = 32,
  parameter int USER_W = 1,
  parameter int MODE   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DATA_W-1:0]   s_tdata,
  input  logic [DATA_W/8-1:0] s_tkeep,
  input  logic [DATA_W/8-1:0] s_tstrb,
  input  logic                s_tlast,
  input  logic [USER_W-1:0]   s_tuser,
  input  logic                s_tvalid,
  output logic                s_tready,
  output logic [DATA_W-1:0]   m_tdata,
  output logic [DATA_W/8-1:0] m_tkeep,
  output logic [DATA_W/8-1:0] m_tstrb,
  output logic                m_tlast,
  output logic [USER_W-1:0]   m_tuser,
  output logic                m_tvalid,
  input  logic                m_tready
);
  localparam int KEEP_W = DATA_W / 8;
  localparam int PW     = DATA_W + 2 * KEEP_W + 1 + USER_W;

  logic [PW-1:0] pay_in, pay_out;
  assign pay_in = {s_tuser, s_tlast, s_tstrb, s_tkeep, s_tdata};
  assign {m_tuser, m_tlast, m_tstrb, m_tkeep, m_tdata} = pay_out;

  generate
    if (MODE == 0) begin : g_bypass
      assign pay_out  = pay_in;
      assign m_tvalid = s_tvalid;
      assign s_tready = m_tready;
    end else if (MODE == 1) begin : g_fwd
      logic          out_v;
      logic [PW-1:0] out_d;
      assign s_tready = m_tready | ~out_v;
      assign m_tvalid = out_v;
      assign pay_out  = out_d;
      always_ff @(posedge clk) begin
        if (!rst_n)        out_v <= 1'b0;
        else if (s_tready) out_v <= s_tvalid;
      end
      always_ff @(posedge clk)
        if (s_tready && s_tvalid) out_d <= pay_in;
    end else if (MODE == 2) begin : g_rev
      logic          skid_v;
      logic [PW-1:0] skid_d;
      assign s_tready = ~skid_v;
      assign m_tvalid = skid_v | s_tvalid;
      assign pay_out  = skid_v ? skid_d : pay_in;
      always_ff @(posedge clk) begin
        if (!rst_n)                    skid_v <= 1'b0;
        else if (m_tready)             skid_v <= 1'b0;
        else if (s_tvalid && !skid_v)  skid_v <= 1'b1;
      end
      always_ff @(posedge clk)
        if (!skid_v && s_tvalid && !m_tready) skid_d <= pay_in;
    end else begin : g_both
      logic          main_v, skid_v;
      logic [PW-1:0] main_d, skid_d;
      assign s_tready = ~skid_v;
      assign m_tvalid = main_v;
      assign pay_out  = main_d;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          main_v <= 1'b0;
          skid_v <= 1'b0;
        end else if (skid_v) begin
          if (m_tready) begin
            main_d <= skid_d;
            skid_v <= 1'b0;
          end
        end else if (s_tvalid) begin
          if (!main_v || m_tready) begin
            main_v <= 1'b1;
            main_d <= pay_in;
          end else begin
            skid_v <= 1'b1;
            skid_d <= pay_in;
          end
        end else if (m_tready) begin
          main_v <= 1'b0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/axis_reg_slice_chk.sv
module axis_reg_slice_chk #(
  parameter int MODE = 3,
  parameter int PW   = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_tvalid,
  input logic          s_tready,
  input logic [PW-1:0] s_pay,
  input logic          m_tvalid,
  input logic          m_tready,
  input logic [PW-1:0] m_pay
);
  localparam logic [2:0] CAP = (MODE == 0) ? 3'd0 : (MODE == 3) ? 3'd2 : 3'd1;

  logic [2:0] occ;
  logic       rst_q = 1'b1;

  always_ff @(posedge clk) begin
    rst_q <= rst_n;
    if (!rst_n) occ <= 3'd0;
    else occ <= occ + {2'd0, s_tvalid & s_tready} - {2'd0, m_tvalid & m_tready};
  end

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n) occ <= CAP); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_pay)); // R8

  always_ff @(posedge clk)
    if ((MODE % 2 == 1) && rst_n && !rst_q)
      AST_RST_IDLE: assert (!m_tvalid); // R10

  generate
    if (MODE == 0) begin : g_a_byp
      AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid == s_tvalid && s_tready == m_tready && m_pay == s_pay); // R2
    end
    if (MODE == 2) begin : g_a_rev
      AST_REV_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        s_tready |-> m_tvalid == s_tvalid && (!s_tvalid || m_pay == s_pay)); // R4
    end
    if (MODE >= 2) begin : g_a_rdy
      AST_READY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_tready) |-> $past(m_tready)); // R5
    end
  endgenerate
endmodule

bind axis_reg_slice axis_reg_slice_chk #(.MODE(MODE), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .s_tvalid(s_tvalid), .s_tready(s_tready), .s_pay(pay_in),
  .m_tvalid(m_tvalid), .m_tready(m_tready), .m_pay(pay_out)
);

// File: tb/axis_reg_slice_tb.sv
module axis_reg_slice_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0;
  int   checks = 0;
  int   errors = 0;
  int   done_cnt = 0;

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int lane, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s lane %0d: actual %0d expected %0d", req, lane, act, exp);
    end
  endtask

  function automatic logic [12:0] exp_pay(input int k);
    logic [31:0] kk, d;
    kk = k;
    d  = kk * 37 + 5;
    return {kk[3:2], kk[1] & kk[0], kk[1], kk[0], d[7:0]};
  endfunction

  function automatic bit hashb(input int t, input int salt);
    logic [31:0] h;
    h = t * 32'h9E3779B1 + salt * 7919;
    return h[17] ^ h[23];
  endfunction

  function automatic bit sink_pat(input int k, input int t, input int salt);
    case (k)
      0: return 1'b0;
      1: return 1'b1;
      2: return t[0];
      default: return hashb(t, salt + 11);
    endcase
  endfunction

  function automatic bit src_pat(input int k, input int t, input int salt);
    case (k)
      0: return 1'b1;
      1: return ~t[0];
      2: return hashb(t, salt);
      default: return (t % 4) == 0;
    endcase
  endfunction

  for (genvar L = 0; L < 4; L++) begin : g_lane
    localparam int M   = (L == 0) ? 3 : L - 1;
    localparam int CAP = (M == 0) ? 0 : (M == 3) ? 2 : 1;
    logic        s_valid, s_ready, m_valid, m_ready;
    logic [12:0] s_pay, m_pay;

    if (L == 0) begin : g_def
      axis_reg_slice #(.DATA_W(8), .USER_W(2)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .s_tdata(s_pay[7:0]), .s_tkeep(s_pay[8]), .s_tstrb(s_pay[9]),
        .s_tlast(s_pay[10]), .s_tuser(s_pay[12:11]), .s_tvalid(s_valid), .s_tready(s_ready),
        .m_tdata(m_pay[7:0]), .m_tkeep(m_pay[8]), .m_tstrb(m_pay[9]),
        .m_tlast(m_pay[10]), .m_tuser(m_pay[12:11]), .m_tvalid(m_valid), .m_tready(m_ready));
    end else begin : g_var
      axis_reg_slice #(.DATA_W(8), .USER_W(2), .MODE(M)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .s_tdata(s_pay[7:0]), .s_tkeep(s_pay[8]), .s_tstrb(s_pay[9]),
        .s_tlast(s_pay[10]), .s_tuser(s_pay[12:11]), .s_tvalid(s_valid), .s_tready(s_ready),
        .m_tdata(m_pay[7:0]), .m_tkeep(m_pay[8]), .m_tstrb(m_pay[9]),
        .m_tlast(m_pay[10]), .m_tuser(m_pay[12:11]), .m_tvalid(m_valid), .m_tready(m_ready));
    end

    initial begin
      int sent, rcvd, g, tput;
      bit fired;
      sent = 0; rcvd = 0; g = 0; tput = 0; fired = 1'b0;
      s_valid = 1'b1; s_pay = exp_pay(0); m_ready = 1'b0;
      wait (go);
      for (int c = 0; c < 17; c++) begin
        for (int t = 0; t < 100; t++) begin
          m_ready = (c == 16) ? 1'b1 : sink_pat(c % 4, g, L);
          if (!s_valid || fired) begin
            s_valid = (c == 16) ? 1'b0 : src_pat(c / 4, g, L);
            s_pay   = exp_pay(sent);
          end
          #2;
          if (g == 0) begin
            check(m_valid == (M == 0 || M == 2), (M % 2 == 1) ? "R10" : "R2", L, m_valid, (M == 0 || M == 2));
            check(s_ready == (M != 0), (M == 0) ? "R2" : "R10", L, s_ready, (M != 0));
            if (M == 0 || M == 2) check(m_pay == s_pay, "R2 R4 pass-through", L, m_pay, s_pay);
          end
          if (g == 1) begin
            check(m_valid == 1'b1, "R3 R4 R5 capture", L, m_valid, 1);
            check(s_ready == (M == 3), (L == 0) ? "R1" : "R5", L, s_ready, (M == 3));
          end
          if (g == 2) check(s_ready == 1'b0, "R5 second entry", L, s_ready, 0);
          if (m_valid && m_ready) begin
            check(m_pay == exp_pay(rcvd), "R6 R7 beat", L, m_pay, exp_pay(rcvd));
            rcvd++;
            if (c == 1) tput++;
          end
          if (m_valid && !m_ready)
            check(m_pay == exp_pay(rcvd), "R8 hold", L, m_pay, exp_pay(rcvd));
          fired = s_valid && s_ready;
          if (fired) sent++;
          if (c == 0 && t == 99) check(sent == CAP, "R5 R7 capacity", L, sent, CAP);
          if (c == 1 && t == 99) check(tput == 100, "R9 throughput", L, tput, 100);
          g++;
          @(negedge clk);
        end
      end
      check(sent == rcvd, "R7 count", L, rcvd, sent);
      done_cnt++;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    go = 1'b1;
    wait (done_cnt == 4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d lanes done expected 4", done_cnt);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule